// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address. It walks a two-level page table that sits in ordinary memory. A requester presents the virtual address, an access kind (read, write or execute) and the physical base address of the top-level directory. The block then runs the walk on its own:

- It reads one 32-bit directory entry.
- It reads one 32-bit leaf entry from the table that the directory entry names.
- It checks validity and access rights.
- When a write finds the page still clean, it stores the leaf entry back with its modified flag set.

Each step is a single word transaction on a simple memory port. A transaction completes only when the memory returns a response-valid strobe, so the memory may take any number of cycles. The walk ends with a one-cycle response that carries either the physical address or a fault code.

The block serves one walk at a time. It raises `busy` from the cycle after acceptance until the response cycle, and it ignores new requests during that time. Pages are 4 KiB. Each directory and each table holds 1024 four-byte entries.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `rspValid` and `memReqValid` are all low.
- R2: A request is accepted only while `busy` is low. `busy` is high from the next cycle until the response cycle, and a request made while busy starts no walk. The first memory access is a read at `{ptBase[31:2],2'b00} + 4*vaddr[31:22]`; the two low base bits are ignored.
- R3: The second memory access is a read at `{dirEntry[31:12],12'h000} + 4*vaddr[21:12]`.
- R4: Entry layout: bits 31:12 hold the page number, bit 0 is valid, bit 1 read-allowed, bit 2 write-allowed, bit 3 execute-allowed and bit 4 the modified (dirty) flag.
- R5: A walk with no fault returns `rspFault` = 0 and `rspPaddr` = `{leafEntry[31:12], vaddr[11:0]}`.
- R6: A directory entry with bit 0 clear ends the walk with `rspFault` = 1 (page fault), and no leaf read is made.
- R7: A leaf entry with bit 0 clear ends the walk with `rspFault` = 1. Validity is checked before rights.
- R8: `reqAccess` encodes 0 = read, 1 = write, 2 = execute and 3 = reserved. Read needs leaf bit 1, write needs bit 2 and execute needs bit 3. Reserved is never allowed. A denied access gives `rspFault` = 2 (protection fault).
- R9: A permitted write whose leaf has bit 4 clear makes one memory write to the leaf's address, with the leaf value OR 0x10, before the response. Every other walk makes no memory write.
- R10: `rspValid` is high for exactly one cycle per walk. `rspPaddr` is zero when `rspFault` is nonzero.
- R11: `memReqValid`, `memReqAddr` and `memReqWrite` stay steady until `memRspValid` arrives, whatever the latency.
- R12: `ptBase`, `reqVaddr` and `reqAccess` are captured at acceptance. Changing them during a walk has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a walk (taken when not busy) |
| reqVaddr | input | 32 | Virtual address to translate |
| reqAccess | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| ptBase | input | 32 | Physical base of the directory |
| busy | output | 1 | Walk in progress |
| rspValid | output | 1 | One-cycle response strobe |
| rspPaddr | output | 32 | Translated physical address |
| rspFault | output | 2 | 0 none, 1 page fault, 2 protection fault |
| memReqValid | output | 1 | Memory transaction pending |
| memReqWrite | output | 1 | Pending transaction is a write |
| memReqAddr | output | 32 | Word address of the transaction |
| memReqWdata | output | 32 | Write data |
| memRspValid | input | 1 | Transaction complete |
| memRspData | input | 32 | Read data, valid with memRspValid |

## Verification
The assertions watch these properties on every cycle:
- The memory request stays steady while it waits.
- The response is a single-cycle pulse.
- An idle walker stays quiet.
- An invalid directory entry leads straight to a response.
- A write-back happens only for a write whose leaf was clean.

Only the bench scenarios can show the rest:
- The exact read addresses and the order of the two reads.
- The physical address that comes back.
- The fault code chosen for each mix of valid and rights bits, across varied latency.
- That inputs changed or requests made during a walk are ignored.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  localparam int VA_W   = 32;
  localparam int IDX_W  = 10;
  localparam int OFF_W  = 12;
  localparam int PPN_W  = VA_W - OFF_W;
  localparam int DIR_HI = VA_W - 1;
  localparam int DIR_LO = VA_W - IDX_W;
  localparam int TBL_HI = DIR_LO - 1;
  localparam int TBL_LO = OFF_W;

  // entry flag positions
  localparam int BIT_V = 0;
  localparam int BIT_R = 1;
  localparam int BIT_W = 2;
  localparam int BIT_X = 3;
  localparam int BIT_D = 4;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_t;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_PAGE = 2'd1,
    FLT_PROT = 2'd2
  } fault_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR,
    ST_LEAF,
    ST_DIRTY,
    ST_RESP
  } walk_st_t;

  typedef struct packed {
    logic loadReq;
    logic loadDir;
    logic loadLeaf;
    logic leafPhase;
    logic dirtyPhase;
  } walk_ctl_t;

  typedef struct packed {
    logic entryValid;
    logic permOk;
    logic needDirty;
  } walk_sts_t;
endpackage

// File: rtl/pt_walk_dpath.sv
module pt_walk_dpath
  import pt_walk_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  walk_ctl_t       ctl,
  input  logic [VA_W-1:0] reqVaddr,
  input  logic [1:0]      reqAccess,
  input  logic [VA_W-1:0] ptBase,
  input  logic [VA_W-1:0] memRspData,
  output walk_sts_t       sts,
  output logic [VA_W-1:0] memReqAddr,
  output logic [VA_W-1:0] memReqWdata,
  output logic [VA_W-1:0] rspPaddr,
  output logic [1:0]      rspFault
);
  logic [VA_W-1:0]  vaddrQ;
  acc_t             accQ;
  logic [VA_W-1:2]  baseQ;
  logic [PPN_W-1:0] dirPpnQ;
  logic [VA_W-1:0]  leafQ;
  fault_t           faultQ;

  logic [VA_W-1:0]  dirAddr;
  logic [VA_W-1:0]  leafAddr;
  logic             permAllowed;

  // rights check against the entry arriving on the response bus
  always_comb begin
    unique case (accQ)
      ACC_READ:  permAllowed = memRspData[BIT_R];
      ACC_WRITE: permAllowed = memRspData[BIT_W];
      ACC_EXEC:  permAllowed = memRspData[BIT_X];
      default:   permAllowed = 1'b0;
    endcase
  end

  assign sts.entryValid = memRspData[BIT_V];
  assign sts.permOk     = permAllowed;
  assign sts.needDirty  = (accQ == ACC_WRITE) && !memRspData[BIT_D];

  assign dirAddr  = {baseQ, 2'b00} + VA_W'({vaddrQ[DIR_HI:DIR_LO], 2'b00});
  assign leafAddr = {dirPpnQ, {OFF_W{1'b0}}} + VA_W'({vaddrQ[TBL_HI:TBL_LO], 2'b00});

  assign memReqAddr  = (ctl.leafPhase || ctl.dirtyPhase) ? leafAddr : dirAddr;
  assign memReqWdata = leafQ | (VA_W'(1) << BIT_D);

  assign rspFault = faultQ;
  assign rspPaddr = (faultQ == FLT_NONE) ? {leafQ[VA_W-1:OFF_W], vaddrQ[OFF_W-1:0]}
                                         : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ  <= '0;
      accQ    <= ACC_READ;
      baseQ   <= '0;
      dirPpnQ <= '0;
      leafQ   <= '0;
      faultQ  <= FLT_NONE;
    end else begin
      if (ctl.loadReq) begin
        vaddrQ <= reqVaddr;
        accQ   <= acc_t'(reqAccess);
        baseQ  <= ptBase[VA_W-1:2];
        faultQ <= FLT_NONE;
      end
      if (ctl.loadDir) begin
        dirPpnQ <= memRspData[VA_W-1:OFF_W];
        if (!memRspData[BIT_V]) faultQ <= FLT_PAGE;
      end
      if (ctl.loadLeaf) begin
        leafQ <= memRspData;
        if (!memRspData[BIT_V])  faultQ <= FLT_PAGE;
        else if (!permAllowed)   faultQ <= FLT_PROT;
        else                     faultQ <= FLT_NONE;
      end
    end
  end

  AST_WB_ONLY_CLEAN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.dirtyPhase |-> (accQ == ACC_WRITE) && !leafQ[BIT_D]); // R9

  AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.leafPhase && !ctl.loadReq && $past(ctl.leafPhase)) |-> $stable(baseQ)); // R12
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      memRspValid,
  input  walk_sts_t sts,
  output walk_ctl_t ctl,
  output logic      busy,
  output logic      rspValid,
  output logic      memReqValid,
  output logic      memReqWrite
);
  walk_st_t state, stateNext;

  always_comb begin
    stateNext   = state;
    ctl         = '0;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    rspValid    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.loadReq = 1'b1;
          stateNext   = ST_DIR;
        end
      end
      ST_DIR: begin
        memReqValid = 1'b1;
        if (memRspValid) begin
          ctl.loadDir = 1'b1;
          stateNext   = sts.entryValid ? ST_LEAF : ST_RESP;
        end
      end
      ST_LEAF: begin
        ctl.leafPhase = 1'b1;
        memReqValid   = 1'b1;
        if (memRspValid) begin
          ctl.loadLeaf = 1'b1;
          if (sts.entryValid && sts.permOk && sts.needDirty) stateNext = ST_DIRTY;
          else                                               stateNext = ST_RESP;
        end
      end
      ST_DIRTY: begin
        ctl.dirtyPhase = 1'b1;
        memReqValid    = 1'b1;
        memReqWrite    = 1'b1;
        if (memRspValid) stateNext = ST_RESP;
      end
      ST_RESP: begin
        rspValid  = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R10

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memRspValid) |=> memReqValid); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReqValid && !rspValid); // R1

  AST_DIR_INVALID_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DIR && memRspValid && !sts.entryValid) |=> rspValid); // R6

  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReqWrite) |-> $past(memRspValid)); // R9
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [31:0] reqVaddr,
  input  logic [1:0]  reqAccess,
  input  logic [31:0] ptBase,
  output logic        busy,
  output logic        rspValid,
  output logic [31:0] rspPaddr,
  output logic [1:0]  rspFault,
  output logic        memReqValid,
  output logic        memReqWrite,
  output logic [31:0] memReqAddr,
  output logic [31:0] memReqWdata,
  input  logic        memRspValid,
  input  logic [31:0] memRspData
);
  walk_ctl_t ctl;
  walk_sts_t sts;

  pt_walk_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memRspValid (memRspValid),
    .sts         (sts),
    .ctl         (ctl),
    .busy        (busy),
    .rspValid    (rspValid),
    .memReqValid (memReqValid),
    .memReqWrite (memReqWrite)
  );

  pt_walk_dpath u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .reqVaddr    (reqVaddr),
    .reqAccess   (reqAccess),
    .ptBase      (ptBase),
    .memRspData  (memRspData),
    .sts         (sts),
    .memReqAddr  (memReqAddr),
    .memReqWdata (memReqWdata),
    .rspPaddr    (rspPaddr),
    .rspFault    (rspFault)
  );

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memRspValid) |=> $stable(memReqAddr) && $stable(memReqWrite)); // R11
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [31:0] reqVaddr;
  logic [1:0]  reqAccess;
  logic [31:0] ptBase;
  logic        busy, rspValid, memReqValid, memReqWrite;
  logic [31:0] rspPaddr, memReqAddr, memReqWdata;
  logic [1:0]  rspFault;
  logic        memRspValid;
  logic [31:0] memRspData;

  always #10 clk = ~clk;

  pt_walker u0 (.*);

  int nChecks = 0;
  int nFail   = 0;

  logic [31:0] dirE, leafE;
  int          lat;
  int          rdCnt, wrCnt;
  logic [31:0] rdAddr0, rdAddr1, wrAddr, wrData;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model: first read of a walk returns dirE, later reads leafE
  initial begin
    int cnt;
    cnt = 0;
    memRspValid = 1'b0;
    memRspData  = '0;
    forever begin
      @(negedge clk);
      if (memRspValid) begin
        memRspValid = 1'b0;
        cnt = 0;
      end else if (memReqValid) begin
        if (cnt >= lat) begin
          memRspValid = 1'b1;
          if (memReqWrite) begin
            wrCnt++;
            wrAddr = memReqAddr;
            wrData = memReqWdata;
            memRspData = '0;
          end else begin
            if (rdCnt == 0) rdAddr0 = memReqAddr;
            if (rdCnt == 1) rdAddr1 = memReqAddr;
            memRspData = (rdCnt == 0) ? dirE : leafE;
            rdCnt++;
          end
        end else begin
          cnt++;
        end
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [1:0] acc,
                      input logic [31:0] base, input logic [31:0] de,
                      input logic [31:0] le, input int l, input bit spur);
    logic [31:0] expDir, expLeaf, expPa, expWa, expWd;
    logic [1:0]  expFlt;
    int          expRd, expWr, w;
    bit          allowed;
    // expected values from the requirements
    expDir = {base[31:2], 2'b00} + {20'd0, va[31:22], 2'b00};   // R2
    expLeaf = {de[31:12], 12'h000} + {20'd0, va[21:12], 2'b00}; // R3
    expWa = expLeaf;
    expWd = le | 32'h10;
    expPa = 32'h0;
    expWr = 0;
    case (acc)                                                   // R8
      2'd0: allowed = le[1];
      2'd1: allowed = le[2];
      2'd2: allowed = le[3];
      default: allowed = 1'b0;
    endcase
    if (!de[0]) begin expFlt = 2'd1; expRd = 1; end              // R6
    else if (!le[0]) begin expFlt = 2'd1; expRd = 2; end         // R7
    else if (!allowed) begin expFlt = 2'd2; expRd = 2; end       // R8
    else begin
      expFlt = 2'd0; expRd = 2;
      expPa = {le[31:12], va[11:0]};                             // R5
      if (acc == 2'd1 && !le[4]) expWr = 1;                      // R9
    end

    dirE = de; leafE = le; lat = l; rdCnt = 0; wrCnt = 0;
    @(negedge clk);
    reqVaddr = va; reqAccess = acc; ptBase = base; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    // R12: disturb captured inputs mid-walk
    ptBase = $urandom; reqVaddr = $urandom; reqAccess = 2'($urandom);
    check(busy == 1'b1, "R2", "busy after accept", 32'(busy), 32'd1);
    w = 0;
    while (!rspValid && w < 400) begin
      reqValid = spur ? 1'($urandom_range(0, 1)) : 1'b0;         // R2 ignored while busy
      @(negedge clk);
      w++;
    end
    reqValid = 1'b0;
    if (!rspValid) begin
      check(1'b0, "R10", "response timeout", 32'(rspValid), 32'd1);
      return;
    end
    check(rspFault == expFlt, "R6/R7/R8", "fault code", 32'(rspFault), 32'(expFlt));
    check(rspPaddr == expPa, "R5_R10", "paddr", rspPaddr, expPa);
    check(rdCnt == expRd, "R6", "read count", 32'(rdCnt), 32'(expRd));
    check(rdAddr0 == expDir, "R2", "directory addr", rdAddr0, expDir);
    if (expRd == 2)
      check(rdAddr1 == expLeaf, "R3", "leaf addr", rdAddr1, expLeaf);
    check(wrCnt == expWr, "R9", "write count", 32'(wrCnt), 32'(expWr));
    if (expWr == 1) begin
      check(wrAddr == expWa, "R9", "write addr", wrAddr, expWa);
      check(wrData == expWd, "R9", "write data", wrData, expWd);
    end
    @(negedge clk);
    check(rspValid == 1'b0, "R10", "single pulse", 32'(rspValid), 32'd0);
    check(busy == 1'b0, "R2", "idle after response", 32'(busy), 32'd0);
    @(negedge clk);
    check(rdCnt == expRd, "R2", "no walk from busy-time request", 32'(rdCnt), 32'(expRd));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R11", "watchdog", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; reqValid = 1'b0; reqVaddr = '0; reqAccess = '0; ptBase = '0;
    lat = 0; rdCnt = 0; wrCnt = 0;
    dirE = '0; leafE = '0;
    rdAddr0 = '0; rdAddr1 = '0; wrAddr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1", "busy", 32'(busy), 32'd0);
    check(rspValid == 1'b0, "R1", "rspValid", 32'(rspValid), 32'd0);
    check(memReqValid == 1'b0, "R1", "memReqValid", 32'(memReqValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R5 R9 worked example: write to a clean page
    walk(32'h7192a44c, 2'd1, 32'h10005000, 32'h12345001, 32'h14817007, 2, 1'b1);
    // R9 write to a page already dirty: no write-back
    walk(32'h7192a44c, 2'd1, 32'h10005000, 32'h12345001, 32'h14817017, 1, 1'b0);
    // R9 read never writes
    walk(32'h00401abc, 2'd0, 32'h20000000, 32'h00abc001, 32'h55555003, 0, 1'b0);
    // R6 invalid directory, immediate memory
    walk(32'hffc00000, 2'd0, 32'h30000000, 32'h12345000, 32'h14817003, 0, 1'b1);
    // R7 invalid leaf with full rights: page fault wins
    walk(32'h12345678, 2'd2, 32'h30000000, 32'h00111001, 32'h2222200e, 3, 1'b0);
    // R8 read with no read right
    walk(32'h12345678, 2'd0, 32'h30000000, 32'h00111001, 32'h2222200d, 0, 1'b0);
    // R8 execute allowed
    walk(32'h0badf00d, 2'd2, 32'h40000000, 32'h00222001, 32'h33333009, 0, 1'b0);
    // R8 reserved access always denied
    walk(32'h0badf00d, 2'd3, 32'h40000000, 32'h00222001, 32'h3333301f, 0, 1'b0);
    // R2 base low bits ignored; R11 long latency
    walk(32'h80000fff, 2'd0, 32'h50000003, 32'h00333001, 32'h44444003, 10, 1'b1);
    // R4 R12 randomised walks
    for (int i = 0; i < 150; i++) begin
      logic [31:0] de, le;
      de = $urandom; le = $urandom;
      if ($urandom_range(0, 7) != 0) de[0] = 1'b1;
      if ($urandom_range(0, 7) != 0) le[0] = 1'b1;
      walk($urandom, 2'($urandom_range(0, 3)), $urandom, de, le,
           $urandom_range(0, 4), 1'($urandom_range(0, 1)));
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule